// File: doc/BRIEF.md
# Most-Deficit Head-Cache Replenishment Arbiter

This block keeps the books for the small fast head cache that sits in front of a large, slow bulk memory in a packet buffer holding many logical FIFO queues. For every queue it tracks how many bytes the cache currently holds and how many refill blocks are on their way from bulk memory. Readers consume at most one byte per timeslot, and each read names a queue. Each read is answered one cycle later with a hit or an underflow flag.

Time is cut into epochs of `BLK_BYTES` timeslots. In each epoch the block may issue at most one refill command, naming one queue. Bulk memory then moves one block of `BLK_BYTES` bytes into that queue's share of the cache and confirms it with a fill acknowledgement. The queue chosen is the one with the largest deficit, meaning the largest free room in its share once outstanding refills are counted.

At the first slot of each epoch, the block takes a snapshot of all deficits into a pipelined comparator tree. It acts on the winner in the epoch's last slot. The search has `BLK_BYTES - 1` cycles to settle, so the parameters must satisfy `BLK_BYTES >= ceil(log2 NUM_Q) + 2` and `CAP_BYTES >= BLK_BYTES`.

Top module: `mdq_replenish_arbiter`

## Requirements
- R1: While reset is held, `rsp_hit`, `rsp_underflow` and `rpl_valid` are 0. Leaving reset, every queue's cache share is treated as full (`CAP_BYTES` bytes), no refill is outstanding, and the first cycle after release is slot 0 of an epoch.
- R2: A request in cycle t to queue q gives, in cycle t+1, `rsp_hit`=1 if q held at least one byte in cycle t, and `rsp_underflow`=1 otherwise. A hit removes one byte from q. Without a request, both flags are 0, and they are never 1 together.
- R3: `rpl_valid` can only be 1 in the cycle after the last slot of an epoch, that is, in cycles k*`BLK_BYTES` after release (k >= 1). There is at most one refill command per epoch.
- R4: A queue's deficit is `CAP_BYTES` minus its cached bytes minus `BLK_BYTES` times its outstanding refills. The command issued at the end of an epoch names the queue whose deficit was largest at that epoch's slot 0, and that queue's outstanding count rises by one.
- R5: When the largest snapshot deficit is shared, the command goes to the lowest queue index among the tied queues.
- R6: When the largest snapshot deficit is below `BLK_BYTES`, no command is issued in that epoch.
- R7: A fill acknowledgement for a queue with an outstanding refill adds `BLK_BYTES` bytes to it and retires one outstanding refill. An acknowledgement for a queue with nothing outstanding changes nothing.
- R8: A request and a fill acknowledgement for the same queue in the same cycle both take effect. The hit or underflow flag is judged on the byte count from before the fill.
- R9: No queue's cached byte count ever exceeds `CAP_BYTES`.
- R10: With the default sizing, prompt acknowledgements (within a few cycles), and one request per slot spread round robin over the queues or aimed at a single queue, no request underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A byte read is requested this slot |
| req_qid | input | QID_W | Queue the byte is read from |
| rsp_hit | output | 1 | Previous slot's request found a cached byte |
| rsp_underflow | output | 1 | Previous slot's request found its queue empty |
| rpl_valid | output | 1 | Refill command for one block |
| rpl_qid | output | QID_W | Queue to be refilled |
| fill_valid | input | 1 | Bulk memory has delivered one block |
| fill_qid | input | QID_W | Queue the delivered block belongs to |

## Verification
The byte counter of one queue can be pulled down by a read and pushed up by a fill acknowledgement in the same slot. The refill decision can also land in the very slot where such reads and fills change the counters it was taken from. The bench provokes the first case by draining a queue to empty while holding its acknowledgements back, then presenting a read and a fill for that queue together. The result is judged by an underflow flag on that read followed by hits on the next reads. The second case is judged by a scoreboard model. The model takes its own snapshot at slot 0 and predicts every hit, underflow and command cycle by cycle, including a two-way tie and a forged acknowledgement that must leave the counters untouched.

// File: rtl/mdq_pkg.sv
package mdq_pkg;

    // Width needed to encode values 0..n-1 (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of pairwise comparison levels for n candidates.
    function automatic int tree_levels(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mdq_epoch_timer.sv
module mdq_epoch_timer #(
    parameter int BLK_BYTES = 6,
    parameter int SLOT_W    = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic epoch_first,
    output logic epoch_last
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.slot == SLOT_W'(BLK_BYTES - 1)) begin
            tmr_d.slot = '0;
        end else begin
            tmr_d.slot = tmr_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign epoch_first = (tmr_q.slot == '0);
    assign epoch_last  = (tmr_q.slot == SLOT_W'(BLK_BYTES - 1));

    // The slot counter must wrap inside the epoch (supports R3).
    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.slot <= SLOT_W'(BLK_BYTES - 1));
endmodule

// File: rtl/mdq_queue_bank.sv
module mdq_queue_bank #(
    parameter int NUM_Q     = 5,
    parameter int QID_W     = 3,
    parameter int CAP_BYTES = 24,
    parameter int BLK_BYTES = 6,
    parameter int CNT_W     = 5,
    parameter int INF_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [QID_W-1:0]            req_qid,
    input  logic                        fill_valid,
    input  logic [QID_W-1:0]            fill_qid,
    input  logic                        issue_valid,
    input  logic [QID_W-1:0]            issue_qid,
    output logic                        rsp_hit,
    output logic                        rsp_underflow,
    output logic [NUM_Q-1:0][CNT_W-1:0] deficit
);
    typedef struct packed {
        logic [NUM_Q-1:0][CNT_W-1:0] occ;
        logic [NUM_Q-1:0][INF_W-1:0] infl;
        logic                        hit;
        logic                        uf;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [NUM_Q-1:0] sel_v;
    logic [NUM_Q-1:0] take_v;
    logic [NUM_Q-1:0] give_v;
    logic [NUM_Q-1:0] add_v;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_qsel
        assign sel_v[i]  = req_valid && (req_qid == QID_W'(i));
        assign take_v[i] = sel_v[i] && (bank_q.occ[i] != '0);
        assign give_v[i] = fill_valid && (fill_qid == QID_W'(i)) && (bank_q.infl[i] != '0);
        assign add_v[i]  = issue_valid && (issue_qid == QID_W'(i));
        assign deficit[i] = CNT_W'(CAP_BYTES - int'(bank_q.occ[i])
                                   - int'(bank_q.infl[i]) * BLK_BYTES);
    end

    always_comb begin
        bank_d     = bank_q;
        bank_d.hit = |take_v;
        bank_d.uf  = |(sel_v & ~take_v);
        for (int i = 0; i < NUM_Q; i++) begin
            bank_d.occ[i]  = bank_q.occ[i]
                           + (give_v[i] ? CNT_W'(BLK_BYTES) : CNT_W'(0))
                           - (take_v[i] ? CNT_W'(1) : CNT_W'(0));
            bank_d.infl[i] = bank_q.infl[i]
                           + (add_v[i]  ? INF_W'(1) : INF_W'(0))
                           - (give_v[i] ? INF_W'(1) : INF_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_Q; i++) begin
                bank_q.occ[i]  <= CNT_W'(CAP_BYTES);
                bank_q.infl[i] <= '0;
            end
            bank_q.hit <= 1'b0;
            bank_q.uf  <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rsp_hit       = bank_q.hit;
    assign rsp_underflow = bank_q.uf;

    assert_flag_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_underflow));

    assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_hit && !rsp_underflow);

    assert_issue_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> deficit[issue_qid] >= CNT_W'(BLK_BYTES));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_qchk
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            bank_q.occ[i] <= CNT_W'(CAP_BYTES));

        assert_stray_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_valid && fill_qid == QID_W'(i) && bank_q.infl[i] == '0 && !sel_v[i])
            |=> $stable(bank_q.occ[i]));
    end
endmodule

// File: rtl/mdq_max_tree.sv
module mdq_max_tree #(
    parameter int NUM_Q  = 5,
    parameter int DEF_W  = 5,
    parameter int QID_W  = 3,
    parameter int LEVELS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NUM_Q-1:0][DEF_W-1:0] leaf_def,
    output logic [DEF_W-1:0]            win_def,
    output logic [QID_W-1:0]            win_qid
);
    localparam int NP = 1 << LEVELS;

    typedef struct packed {
        logic [DEF_W-1:0] def;
        logic [QID_W-1:0] qid;
    } cand_t;

    typedef struct packed {
        cand_t [LEVELS:0][NP-1:0] stg;
    } tree_t;

    tree_t tree_d, tree_q;
    cand_t [NP-1:0] leaves;

    // Right operand wins only if strictly larger: lower index keeps ties.
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        return (hi.def > lo.def) ? hi : lo;
    endfunction

    for (genvar n = 0; n < NP; n++) begin : g_leaf
        if (n < NUM_Q) begin : g_real
            assign leaves[n] = '{def: leaf_def[n], qid: QID_W'(n)};
        end else begin : g_pad
            assign leaves[n] = '0;
        end
    end

    always_comb begin
        tree_d = tree_q;
        if (load) begin
            tree_d.stg[0] = leaves;
        end
        for (int l = 1; l <= LEVELS; l++) begin
            for (int n = 0; n < NP / 2; n++) begin
                tree_d.stg[l][n] = pick(tree_q.stg[l-1][2*n], tree_q.stg[l-1][2*n+1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tree_q <= '0;
        end else begin
            tree_q <= tree_d;
        end
    end

    assign win_def = tree_q.stg[LEVELS][0].def;
    assign win_qid = tree_q.stg[LEVELS][0].qid;

    // A winner index always names a real queue or padding with zero deficit (R4).
    assert_win_real_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_def != '0) |-> (int'(win_qid) < NUM_Q));
endmodule

// File: rtl/mdq_replenish_arbiter.sv
module mdq_replenish_arbiter
    import mdq_pkg::*;
#(
    parameter int NUM_Q     = 5,
    parameter int BLK_BYTES = 6,
    parameter int CAP_BYTES = 24,
    parameter int QID_W     = idx_bits(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [QID_W-1:0] req_qid,
    output logic             rsp_hit,
    output logic             rsp_underflow,
    output logic             rpl_valid,
    output logic [QID_W-1:0] rpl_qid,
    input  logic             fill_valid,
    input  logic [QID_W-1:0] fill_qid
);
    localparam int CNT_W  = $clog2(CAP_BYTES + 1);
    localparam int INF_W  = $clog2(CAP_BYTES / BLK_BYTES + 1);
    localparam int SLOT_W = idx_bits(BLK_BYTES);
    localparam int LEVELS = tree_levels(NUM_Q);

    typedef struct packed {
        logic             rpl_valid;
        logic [QID_W-1:0] rpl_qid;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    logic                        epoch_first;
    logic                        epoch_last;
    logic [NUM_Q-1:0][CNT_W-1:0] deficit;
    logic [CNT_W-1:0]            win_def;
    logic [QID_W-1:0]            win_qid;
    logic                        issue;

    mdq_epoch_timer #(
        .BLK_BYTES (BLK_BYTES),
        .SLOT_W    (SLOT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .epoch_first (epoch_first),
        .epoch_last  (epoch_last)
    );

    mdq_queue_bank #(
        .NUM_Q     (NUM_Q),
        .QID_W     (QID_W),
        .CAP_BYTES (CAP_BYTES),
        .BLK_BYTES (BLK_BYTES),
        .CNT_W     (CNT_W),
        .INF_W     (INF_W)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_qid       (req_qid),
        .fill_valid    (fill_valid),
        .fill_qid      (fill_qid),
        .issue_valid   (issue),
        .issue_qid     (win_qid),
        .rsp_hit       (rsp_hit),
        .rsp_underflow (rsp_underflow),
        .deficit       (deficit)
    );

    mdq_max_tree #(
        .NUM_Q  (NUM_Q),
        .DEF_W  (CNT_W),
        .QID_W  (QID_W),
        .LEVELS (LEVELS)
    ) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (epoch_first),
        .leaf_def (deficit),
        .win_def  (win_def),
        .win_qid  (win_qid)
    );

    assign issue = epoch_last && (win_def >= CNT_W'(BLK_BYTES));

    always_comb begin
        cmd_d           = cmd_q;
        cmd_d.rpl_valid = issue;
        cmd_d.rpl_qid   = issue ? win_qid : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign rpl_valid = cmd_q.rpl_valid;
    assign rpl_qid   = cmd_q.rpl_qid;

    // Commands only appear at an epoch boundary (R3).
    assert_rpl_epoch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_valid |-> epoch_first);

    // A command names a real queue (R4).
    assert_rpl_qid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_valid |-> (int'(rpl_qid) < NUM_Q));
endmodule

// File: tb/mdq_replenish_arbiter_bench.sv
`timescale 1ns/1ps
module mdq_replenish_arbiter_bench;
    localparam int NQ  = 5;
    localparam int BLK = 6;
    localparam int CAP = 24;
    localparam int QW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [QW-1:0] req_qid = '0;
    logic          fill_valid = 1'b0;
    logic [QW-1:0] fill_qid = '0;
    logic          rsp_hit;
    logic          rsp_underflow;
    logic          rpl_valid;
    logic [QW-1:0] rpl_qid;

    always #4 clk = ~clk;

    mdq_replenish_arbiter #(
        .NUM_Q     (NQ),
        .BLK_BYTES (BLK),
        .CAP_BYTES (CAP),
        .QID_W     (QW)
    ) u_mdq_replenish_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_qid       (req_qid),
        .rsp_hit       (rsp_hit),
        .rsp_underflow (rsp_underflow),
        .rpl_valid     (rpl_valid),
        .rpl_qid       (rpl_qid),
        .fill_valid    (fill_valid),
        .fill_qid      (fill_qid)
    );

    typedef struct {
        bit    hit;
        bit    uf;
        bit    rv;
        int    rq;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    occ[NQ];
    int    infl[NQ];
    int    fq[$];
    int    fdue[$];
    int    slot, snap_def, snap_q, cyc;
    int    ack_delay = 2;
    string tag = "R1";
    int    compared = 0;
    int    mismatched = 0;
    int    uf_seen = 0;
    int    tie_first = -1;
    bit    done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            occ[q]  = CAP;
            infl[q] = 0;
        end
        fq.delete();
        fdue.delete();
        slot = 0; snap_def = 0; snap_q = 0; cyc = 0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "rsp_hit in reset", int'(rsp_hit), 0);
        chk("R1", "rsp_underflow in reset", int'(rsp_underflow), 0);
        chk("R1", "rpl_valid in reset", int'(rpl_valid), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
    endtask

    // Drive one slot and push the outputs expected after the next edge.
    task automatic step(input bit rv, input int rq, input bit fen, input int force_q);
        bit   fv;
        int   fqid;
        exp_t e;
        @(negedge clk);
        fv = 1'b0; fqid = 0;
        if (force_q >= 0) begin
            fv = 1'b1; fqid = force_q;
            for (int k = 0; k < fq.size(); k++) begin
                if (fq[k] == force_q) begin
                    fq.delete(k); fdue.delete(k);
                    break;
                end
            end
        end else if (fen && fq.size() > 0 && fdue[0] <= cyc) begin
            fv = 1'b1; fqid = fq.pop_front(); void'(fdue.pop_front());
        end
        req_valid  = rv;
        req_qid    = QW'(rq);
        fill_valid = fv;
        fill_qid   = QW'(fqid);

        e.tag = tag;
        e.hit = rv && occ[rq] > 0;
        e.uf  = rv && occ[rq] == 0;
        e.rv  = 1'b0;
        e.rq  = 0;
        if (slot == BLK - 1 && snap_def >= BLK) begin
            e.rv = 1'b1; e.rq = snap_q;
        end
        if (slot == 0) begin
            snap_def = -1;
            for (int q = 0; q < NQ; q++) begin
                int d;
                d = CAP - occ[q] - infl[q] * BLK;
                if (d > snap_def) begin snap_def = d; snap_q = q; end
            end
        end
        if (rv && occ[rq] > 0) occ[rq]--;
        if (fv && infl[fqid] > 0) begin occ[fqid] += BLK; infl[fqid]--; end
        if (e.rv) begin
            infl[e.rq]++;
            fq.push_back(e.rq);
            fdue.push_back(cyc + 1 + ack_delay);
        end
        exp_q.push_back(e);
        slot = (slot + 1) % BLK;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 1'b1, -1);
    endtask

    // Monitor: pops one expectation per edge and compares it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " R2"}, "rsp_hit", int'(rsp_hit), int'(e.hit));
                chk({e.tag, " R2"}, "rsp_underflow", int'(rsp_underflow), int'(e.uf));
                chk({e.tag, " R3"}, "rpl_valid", int'(rpl_valid), int'(e.rv));
                if (e.rv) chk({e.tag, " R4"}, "rpl_qid", int'(rpl_qid), e.rq);
                if (e.tag == "R10" && rsp_underflow) uf_seen++;
                if (e.tag == "R5" && rpl_valid && tie_first < 0) tie_first = int'(rpl_qid);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state and preloaded caches (first reads hit).
        apply_reset();
        tag = "R1";
        for (int q = 0; q < NQ; q++) step(1'b1, q, 1'b1, -1);

        // R10: round robin, then a single hot queue, prompt fills.
        tag = "R10";
        for (int k = 0; k < 180; k++) step(1'b1, k % NQ, 1'b1, -1);
        for (int k = 0; k < 120; k++) step(1'b1, 2, 1'b1, -1);

        // R6 / R9: idle refill settles below one block of deficit, no more commands.
        tag = "R6 R9";
        idle(60);
        @(posedge clk); #3;
        chk("R10", "underflows under default sizing", uf_seen, 0);

        // R5: queues 1 and 3 reach equal deficit at the same snapshot.
        apply_reset();
        tag = "R5";
        for (int k = 0; k < 12; k++) step(1'b1, (k % 2 == 0) ? 3 : 1, 1'b1, -1);
        idle(18);
        @(posedge clk); #3;
        chk("R5", "first command on tie", tie_first, 1);

        // R7: stray fill to a queue with nothing outstanding must be ignored.
        apply_reset();
        tag = "R7";
        for (int k = 0; k < 6; k++) step(1'b1, 2, 1'b0, -1);
        step(1'b1, 2, 1'b0, 2);
        for (int k = 0; k < 20; k++) step(1'b1, 2, 1'b0, -1);
        idle(30);
        for (int k = 0; k < 10; k++) step(1'b1, 2, 1'b1, -1);

        // R8: read and fill for the same empty queue in one slot.
        apply_reset();
        tag = "R8";
        for (int k = 0; k < 30; k++) step(1'b1, 0, 1'b0, -1);
        step(1'b1, 0, 1'b0, 0);
        step(1'b1, 0, 1'b0, -1);
        step(1'b1, 0, 1'b0, -1);
        idle(40);

        @(posedge clk); #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule